// File: doc/BRIEF.md
# Deep Sleep Entry and Wake Controller

This block moves a small processor system into its lowest power state and brings it back. Software arms the entry through a small register interface and then executes the sleep instruction; the core reports each completed instruction and whether it was the sleep instruction. While the system is asleep the block asks for core power-down. It watches six wake inputs: a watchdog timeout, a brown-out monitor, a clock alarm, an external interrupt pin and a low-power wake comparator, each enabled by its own bit, plus an internal fault monitor that is always active.

Any wake runs a fixed-length power-on reset of the core. The core registers (mode and enables) return to zero. The two context bytes, the wake-cause flags, the exit and brown-out status bits and the I/O hold all keep their values across that reset. The I/O hold stays on until software releases it. The supply monitors, the oscillators and the clock itself are outside the block and arrive as plain inputs.

Top module: `dslp_ctrl`

## Requirements
- R1: When the arm bit (mode register 0, bit 0) has been written to 1 and the next completed instruction is the sleep instruction, the block enters deep sleep. This needs regulator-sleep (bit 1) = 1 and idle-select (bit 2) = 0. `pdn_req` rises the cycle after that instruction.
- R2: Arming is one-shot. Any other completed instruction after the arm write cancels it, and a later sleep instruction then does not enter.
- R3: With regulator-sleep = 0 or idle-select = 1, the sleep instruction does not enter deep sleep.
- R4: If the clock-alarm source is enabled (enable register 1, bit 2) and `rtc_busy` is high, entry is held off. `pdn_req` rises the cycle after `rtc_busy` falls.
- R5: In deep sleep, a wake makes `pdn_req` fall on the next cycle. `por_req` is then high for exactly 16 cycles, and is never high together with `pdn_req`.
- R6: The enable and cause bits use the same positions: 0 watchdog, 1 brown-out, 2 clock alarm, 3 external, 4 low-power. An enabled source that fires in deep sleep sets only its own cause bit (cause register 5), and sources firing together all set their bits. The flags are sticky and each clears by writing 1 to it. Disabled sources and events outside deep sleep neither wake the block nor set flags.
- R7: `fault_det` in deep sleep always wakes the block and sets cause bit 5, whatever the enable bits are.
- R8: A brown-out wake sets status bit 1 (register 4), which clears by writing 1 to it.
- R9: Every wake sets the exit flag (status bit 0), which clears by writing 1 to it.
- R10: The context bytes (registers 2 and 3) keep their value through deep sleep and the wake reset.
- R11: `io_hold` (status bit 2) rises on entry, stays high through the wake reset, and falls only when software writes 1 to status bit 2.
- R12: Register writes are ignored while `pdn_req` or `por_req` is high. The wake reset clears the mode register, including arm, and the enable register.
- R13: The external source reacts to a rising edge. A level that is already high at entry does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Supply-up reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| instr_done | input | 1 | Core completed an instruction this cycle |
| sleep_instr | input | 1 | The completed instruction is the sleep instruction |
| rtc_busy | input | 1 | Clock synchronisation busy |
| wdt_to | input | 1 | Deep-sleep watchdog timeout |
| bor_evt | input | 1 | Brown-out detected |
| rtc_alarm | input | 1 | Clock alarm |
| ext_int | input | 1 | External interrupt pin |
| ulp_wake | input | 1 | Low-power wake comparator |
| fault_det | input | 1 | Internal fault monitor |
| pdn_req | output | 1 | Core power-down request |
| por_req | output | 1 | Core power-on reset request |
| io_hold | output | 1 | Freeze I/O states |
| wake_cause | output | 6 | Sticky wake-cause flags |

## Verification
Entry shows on `pdn_req` one cycle after the sleep-instruction cycle. A wake shows on `por_req` one cycle after the source cycle, and the flags can be read from that cycle on. The bench drives inputs at the falling edge and samples at the next falling edge, so each result is read half a cycle after the edge that produces it. It counts the `por_req` length one falling edge at a time. Each source is swept on its own, and the cause value it expects is the shifted bit for that source.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
   typedef enum logic [1:0] {ST_RUN, ST_SYNC, ST_DEEP, ST_RST} dslp_state_e;

   localparam int A_MODE  = 0;
   localparam int A_EN    = 1;
   localparam int A_CTX0  = 2;
   localparam int A_STAT  = 4;
   localparam int A_CAUSE = 5;

   localparam int MB_ARM    = 0;
   localparam int MB_REGSLP = 1;
   localparam int MB_IDLE   = 2;

   localparam int SB_EXIT = 0;
   localparam int SB_BOR  = 1;
   localparam int SB_HOLD = 2;

   localparam int SRC_WDT = 0;
   localparam int SRC_BOR = 1;
   localparam int SRC_RTC = 2;
   localparam int SRC_EXT = 3;
   localparam int SRC_ULP = 4;
   localparam int NUM_SRC = 5;
endpackage

// File: rtl/dslp_entry.sv
module dslp_entry
   import dslp_pkg::*;
#(
   parameter int POR_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic instr_done,
   input  logic sleep_instr,
   input  logic regslp,
   input  logic idle_sel,
   input  logic rtc_gate,
   input  logic wake_any,
   output logic arm_q,
   output logic pdn_req,
   output logic por_req,
   output logic enter_pls,
   output logic wake_pls
);
   localparam int CNT_W = (POR_CYCLES > 2) ? $clog2(POR_CYCLES) : 1;

   generate
      if (POR_CYCLES < 2) begin : g_bad_por
         $error("POR_CYCLES must be at least 2");
      end
   endgenerate

   dslp_state_e state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic go;

   assign go = arm_q && instr_done && sleep_instr && regslp && !idle_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          arm_q <= 1'b0;
      else if (por_req)    arm_q <= 1'b0;
      else if (arm_set)    arm_q <= 1'b1;
      else if (instr_done) arm_q <= 1'b0;
   end

   always_comb begin
      state_d   = state_q;
      enter_pls = 1'b0;
      case (state_q)
         ST_RUN:  if (go) begin
                     if (rtc_gate) state_d = ST_SYNC;
                     else begin state_d = ST_DEEP; enter_pls = 1'b1; end
                  end
         ST_SYNC: if (!rtc_gate) begin state_d = ST_DEEP; enter_pls = 1'b1; end
         ST_DEEP: if (wake_any) state_d = ST_RST;
         ST_RST:  if (cnt_q == '0) state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_DEEP && wake_any) cnt_q <= CNT_W'(POR_CYCLES - 1);
         else if (state_q == ST_RST && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign pdn_req  = (state_q == ST_DEEP);
   assign por_req  = (state_q == ST_RST);
   assign wake_pls = pdn_req && wake_any;

   AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && instr_done && !arm_set) |=> !arm_q); // R2
   AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn_req) |-> ($past(sleep_instr && instr_done) || $past(state_q == ST_SYNC))); // R1
   AST_WAKE_TO_POR: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_req && wake_any) |=> (por_req && !pdn_req)); // R5
   AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pdn_req && por_req)); // R5
endmodule

// File: rtl/dslp_wake.sv
module dslp_wake
   import dslp_pkg::*;
#(
   parameter bit EXT_RISING = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               asleep,
   input  logic [NUM_SRC-1:0] raw,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               fault,
   input  logic [NUM_SRC:0]   cause_clr,
   output logic               wake_any,
   output logic               bor_wake,
   output logic [NUM_SRC:0]   cause_q
);
   logic [NUM_SRC-1:0] evt;
   logic [NUM_SRC-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         if (i == SRC_EXT) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) prev_q <= 1'b0;
               else        prev_q <= raw[i];
            end
            if (EXT_RISING) begin : g_rise
               assign evt[i] = raw[i] && !prev_q;
            end else begin : g_fall
               assign evt[i] = !raw[i] && prev_q;
            end
         end else begin : g_level
            assign evt[i] = raw[i];
         end
      end
   endgenerate

   assign hit      = evt & src_en;
   assign wake_any = asleep && ((|hit) || fault);
   assign bor_wake = hit[SRC_BOR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~cause_clr) | (wake_any ? {fault, hit} : '0);
   end

   AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_clr == '0) |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R6
   AST_CAUSE_AWAKE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !asleep |=> ((cause_q & ~$past(cause_q)) == '0)); // R6
endmodule

// File: rtl/dslp_regs.sv
module dslp_regs
   import dslp_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 3,
   parameter int CTX_NUM = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               pdn_req,
   input  logic               por_req,
   input  logic               enter_pls,
   input  logic               wake_pls,
   input  logic               bor_wake,
   input  logic               arm_q,
   input  logic [NUM_SRC:0]   cause_q,
   output logic               arm_set,
   output logic               regslp,
   output logic               idle_sel,
   output logic [NUM_SRC-1:0] src_en,
   output logic [NUM_SRC:0]   cause_clr,
   output logic               io_hold
);
   generate
      if (DATA_W < NUM_SRC + 1) begin : g_bad_w
         $error("DATA_W too narrow for the cause register");
      end
      if (CTX_NUM < 1 || CTX_NUM > 2) begin : g_bad_ctx
         $error("CTX_NUM must be 1 or 2");
      end
   endgenerate

   logic wr_ok;
   logic exit_q, borf_q;
   logic [DATA_W-1:0] ctx_q [CTX_NUM];

   assign wr_ok     = wr_en && !pdn_req && !por_req;
   assign arm_set   = wr_ok && (wr_addr == ADDR_W'(A_MODE)) && wr_data[MB_ARM];
   assign cause_clr = (wr_ok && (wr_addr == ADDR_W'(A_CAUSE))) ? wr_data[NUM_SRC:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regslp   <= 1'b0;
         idle_sel <= 1'b0;
         src_en   <= '0;
      end else if (por_req) begin
         regslp   <= 1'b0;
         idle_sel <= 1'b0;
         src_en   <= '0;
      end else if (wr_ok) begin
         if (wr_addr == ADDR_W'(A_MODE)) begin
            regslp   <= wr_data[MB_REGSLP];
            idle_sel <= wr_data[MB_IDLE];
         end
         if (wr_addr == ADDR_W'(A_EN)) src_en <= wr_data[NUM_SRC-1:0];
      end
   end

   generate
      for (genvar i = 0; i < CTX_NUM; i++) begin : g_ctx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctx_q[i] <= '0;
            else if (wr_ok && wr_addr == ADDR_W'(A_CTX0 + i)) ctx_q[i] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exit_q  <= 1'b0;
         borf_q  <= 1'b0;
         io_hold <= 1'b0;
      end else begin
         if (wake_pls) exit_q <= 1'b1;
         else if (wr_ok && wr_addr == ADDR_W'(A_STAT) && wr_data[SB_EXIT]) exit_q <= 1'b0;
         if (wake_pls && bor_wake) borf_q <= 1'b1;
         else if (wr_ok && wr_addr == ADDR_W'(A_STAT) && wr_data[SB_BOR]) borf_q <= 1'b0;
         if (enter_pls) io_hold <= 1'b1;
         else if (wr_ok && wr_addr == ADDR_W'(A_STAT) && wr_data[SB_HOLD]) io_hold <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_MODE):  begin
                              rd_data[MB_ARM]    = arm_q;
                              rd_data[MB_REGSLP] = regslp;
                              rd_data[MB_IDLE]   = idle_sel;
                           end
         ADDR_W'(A_EN):    rd_data[NUM_SRC-1:0] = src_en;
         ADDR_W'(A_STAT):  begin
                              rd_data[SB_EXIT] = exit_q;
                              rd_data[SB_BOR]  = borf_q;
                              rd_data[SB_HOLD] = io_hold;
                           end
         ADDR_W'(A_CAUSE): rd_data[NUM_SRC:0] = cause_q;
         default:          rd_data = '0;
      endcase
      for (int i = 0; i < CTX_NUM; i++) begin
         if (rd_addr == ADDR_W'(A_CTX0 + i)) rd_data = ctx_q[i];
      end
   end

   AST_HOLD_IN_POR: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |-> io_hold); // R11
   AST_CTX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_req || por_req) |=> $stable(ctx_q[0])); // R10
   AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      por_req |=> (src_en == '0)); // R12
endmodule

// File: rtl/dslp_ctrl.sv
module dslp_ctrl
   import dslp_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 3,
   parameter int CTX_NUM    = 2,
   parameter int POR_CYCLES = 16,
   parameter bit EXT_RISING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              instr_done,
   input  logic              sleep_instr,
   input  logic              rtc_busy,
   input  logic              wdt_to,
   input  logic              bor_evt,
   input  logic              rtc_alarm,
   input  logic              ext_int,
   input  logic              ulp_wake,
   input  logic              fault_det,
   output logic              pdn_req,
   output logic              por_req,
   output logic              io_hold,
   output logic [NUM_SRC:0]  wake_cause
);
   logic arm_set, arm_q, regslp, idle_sel, enter_pls, wake_pls, wake_any, bor_wake;
   logic [NUM_SRC-1:0] src_en, raw;
   logic [NUM_SRC:0]   cause_clr;

   always_comb begin
      raw          = '0;
      raw[SRC_WDT] = wdt_to;
      raw[SRC_BOR] = bor_evt;
      raw[SRC_RTC] = rtc_alarm;
      raw[SRC_EXT] = ext_int;
      raw[SRC_ULP] = ulp_wake;
   end

   dslp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTX_NUM(CTX_NUM)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pdn_req(pdn_req), .por_req(por_req),
      .enter_pls(enter_pls), .wake_pls(wake_pls), .bor_wake(bor_wake), .arm_q(arm_q),
      .cause_q(wake_cause), .arm_set(arm_set), .regslp(regslp), .idle_sel(idle_sel),
      .src_en(src_en), .cause_clr(cause_clr), .io_hold(io_hold));

   dslp_entry #(.POR_CYCLES(POR_CYCLES)) entry_i (
      .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .instr_done(instr_done),
      .sleep_instr(sleep_instr), .regslp(regslp), .idle_sel(idle_sel),
      .rtc_gate(src_en[SRC_RTC] && rtc_busy), .wake_any(wake_any), .arm_q(arm_q),
      .pdn_req(pdn_req), .por_req(por_req), .enter_pls(enter_pls), .wake_pls(wake_pls));

   dslp_wake #(.EXT_RISING(EXT_RISING)) wake_i (
      .clk(clk), .rst_n(rst_n), .asleep(pdn_req), .raw(raw), .src_en(src_en),
      .fault(fault_det), .cause_clr(cause_clr), .wake_any(wake_any),
      .bor_wake(bor_wake), .cause_q(wake_cause));

   AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_req && fault_det) |=> (por_req && wake_cause[NUM_SRC])); // R7
endmodule

// File: tb/dslp_ctrl_tb.sv
module dslp_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic instr_done = 1'b0, sleep_instr = 1'b0, rtc_busy = 1'b0, fault_det = 1'b0;
   logic [4:0] src = '0;
   logic pdn_req, por_req, io_hold;
   logic [5:0] wake_cause;
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   dslp_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .instr_done(instr_done),
      .sleep_instr(sleep_instr), .rtc_busy(rtc_busy), .wdt_to(src[0]), .bor_evt(src[1]),
      .rtc_alarm(src[2]), .ext_int(src[3]), .ulp_wake(src[4]), .fault_det(fault_det),
      .pdn_req(pdn_req), .por_req(por_req), .io_hold(io_hold), .wake_cause(wake_cause));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected <100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; instr_done = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; instr_done = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic do_sleep();
      instr_done = 1'b1; sleep_instr = 1'b1;
      @(negedge clk);
      instr_done = 1'b0; sleep_instr = 1'b0;
   endtask

   task automatic enter(input logic [4:0] en, input logic [2:0] mode);
      wr(3'd1, {3'b0, en});
      wr(3'd0, {5'b0, mode});
      do_sleep();
   endtask

   task automatic fire(input logic [4:0] s, input logic f);
      src = src | s; fault_det = f;
      @(negedge clk);
      src = src & ~s; fault_det = 1'b0;
   endtask

   task automatic count_por(output int n);
      n = 0;
      while (por_req && n < 40) begin n++; @(negedge clk); end
   endtask

   task automatic clear_all();
      wr(3'd5, 8'h3f);
      wr(3'd4, 8'h07);
   endtask

   initial begin
      logic [7:0] d;
      int n;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R5 reset pdn", pdn_req, 0);
      chk("R5 reset por", por_req, 0);
      chk("R11 reset hold", io_hold, 0);
      chk("R6 reset cause", wake_cause, 0);

      wr(3'd2, 8'h5a); wr(3'd3, 8'hc3);

      // R6 R8 R9 R11: one source at a time
      for (int s = 0; s < 5; s++) begin
         enter(5'(1 << s), 3'b011);
         chk("R1 entry", pdn_req, 1);
         chk("R11 hold on entry", io_hold, 1);
         tick(2);
         fire(5'(1 << s), 1'b0);
         chk("R5 pdn drops", pdn_req, 0);
         count_por(n);
         chk("R5 por length", n, 16);
         chk("R6 cause one-hot", wake_cause, 1 << s);
         rd(3'd4, d);
         chk("R9 exit flag", d[0], 1);
         chk("R8 bor flag", d[1], (s == 1) ? 1 : 0);
         chk("R11 hold after por", d[2], 1);
         rd(3'd0, d); chk("R12 mode cleared", d, 0);
         rd(3'd1, d); chk("R12 enable cleared", d, 0);
         rd(3'd2, d); chk("R10 ctx0", d, 8'h5a);
         rd(3'd3, d); chk("R10 ctx1", d, 8'hc3);
         tick(3);
         chk("R6 sticky", wake_cause, 1 << s);
         clear_all();
         chk("R6 cleared", wake_cause, 0);
         chk("R11 released", io_hold, 0);
         rd(3'd4, d); chk("R9 R8 cleared", d, 0);
      end

      // R6 disabled source and simultaneous sources; R12 write ignored in sleep
      enter(5'b10101, 3'b011);
      fire(5'b00010, 1'b0);
      chk("R6 disabled no wake", pdn_req, 1);
      wr(3'd2, 8'h11);
      fire(5'b10100, 1'b0);
      count_por(n);
      chk("R6 simultaneous", wake_cause, 6'h14);
      rd(3'd2, d); chk("R12 write in sleep ignored", d, 8'h5a);
      clear_all();

      // R7 fault with no enables
      enter(5'b0, 3'b011);
      tick(2);
      chk("R7 asleep no enables", pdn_req, 1);
      fire(5'b0, 1'b1);
      chk("R7 fault wakes", por_req, 1);
      count_por(n);
      chk("R7 fault flag", wake_cause, 6'h20);
      clear_all();

      // R6 events while awake ignored
      wr(3'd1, 8'h1f);
      fire(5'b11111, 1'b1);
      tick(1);
      chk("R6 awake ignored", wake_cause, 0);
      chk("R6 awake no por", por_req, 0);

      // R2 cancel
      wr(3'd0, 8'h03);
      instr_done = 1'b1; tick(1); instr_done = 1'b0;
      do_sleep();
      chk("R2 cancelled", pdn_req, 0);
      rd(3'd0, d); chk("R2 arm cleared", d[0], 0);

      // R3 mode conditions
      wr(3'd0, 8'h01); do_sleep();
      chk("R3 regslp low", pdn_req, 0);
      wr(3'd0, 8'h07); do_sleep();
      chk("R3 idle high", pdn_req, 0);

      // R4 sync hold-off
      rtc_busy = 1'b1;
      enter(5'b00100, 3'b011);
      tick(3);
      chk("R4 held off", pdn_req, 0);
      rtc_busy = 1'b0;
      tick(1);
      chk("R4 entry after busy", pdn_req, 1);
      fire(5'b00100, 1'b0);
      count_por(n);
      chk("R4 rtc cause", wake_cause, 6'h04);
      clear_all();

      // R13 edge only
      src[3] = 1'b1;
      tick(1);
      enter(5'b01000, 3'b011);
      tick(3);
      chk("R13 level no wake", pdn_req, 1);
      src[3] = 1'b0; tick(1);
      src[3] = 1'b1; tick(1);
      chk("R13 edge wakes", por_req, 1);
      src[3] = 1'b0;
      count_por(n);
      chk("R13 ext cause", wake_cause, 6'h08);
      clear_all();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule